// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block makes a pulse-width-modulated waveform with duty resolution down to a quarter of one timer count. A 10-bit time base is formed from an 8-bit period counter (upper bits) and a 2-bit phase field (lower bits). The phase field advances once for every cycle in which the prescaler enable is high. An 8-bit period value sets where the counter wraps. Software supplies the duty value in two pieces: an 8-bit upper part and a 2-bit lower part. The lower part sits in the control register next to the run bit. The two pieces together form a master duty value.

At every period boundary the master duty value is copied into a shadow (slave) register, and the output latch is set. The latch is then cleared when the time base reaches the shadow value. Duty updates are therefore always glitch-free: whatever software writes during a period is used only from the next boundary onward.

Clearing the run bit stops the time base at zero and pulls the latch low. A separate direction input decides whether the pin is driven at all.

Top module: `pwm10_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, pin_o is 0. Reset clears the time base, the shadow duty, the period, the duty and the control fields.
- R2: With the run bit set, prescaler enable held high and period value P, one PWM period lasts 4*(P+1) clock cycles. When the shadow duty is nonzero, the latch rises exactly when the time base returns to zero.
- R3: For a shadow duty D with 0 < D < 4*(P+1), the output is high for exactly D prescaler ticks in each period.
- R4: A shadow duty of 0 keeps the output low for the whole period.
- R5: A shadow duty of at least 4*(P+1) keeps the output high for the whole period.
- R6: Writes to the duty fields never change the output within the current period. The shadow register changes only at a period boundary.
- R7: When the run bit is 0, the latch is forced low and the time base is held at zero from the next cycle on. After the run bit is set again, the output stays low until the first period boundary, which comes 4*(P+1) ticks later.
- R8: pin_oe equals out_en. While out_en is 0, pin_o is 0.
- R9: While presc_en is low and the run bit is set, the time base and the output latch hold their values.
- R10: The duty value is {duty_hi, duty_lo}, with duty_hi as the upper 8 bits. In ctrl_wd, bit 2 is the run bit and bits 1:0 are duty_lo. Writing duty_lo therefore changes the high time in steps of single ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we | input | 1 | Write strobe for the period value |
| period_wd | input | 8 | New period value P |
| duty_hi_we | input | 1 | Write strobe for the upper duty field |
| duty_hi_wd | input | 8 | New upper 8 duty bits |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wd | input | 3 | Bit 2 is the run bit; bits 1:0 are the lower duty bits |
| presc_en | input | 1 | Advances the time base by one tick when high |
| out_en | input | 1 | Direction control: 1 drives the pin |
| pin_o | output | 1 | Pin value: latch value while driven, 0 otherwise |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The generator is run with several duty values at a short period: nonzero duties that differ only in the lower field, zero, exactly the period length, and far beyond it. High-cycle counts over whole periods then separate correct 10-bit comparison from comparison of the upper byte alone, and show where clamping starts. A duty rewrite placed just after a rising edge, followed by probing at a fixed offset in the same period and again in the next period, tells double-buffered behaviour apart from a direct path. Stopping the prescaler, clearing the run bit, lowering the direction input and changing the period each exercise one gating path. A per-clock reference model compares the pin on every cycle throughout.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int TMR_W_DEF  = 8;
    localparam int FRAC_W_DEF = 2;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_WRAP  = 2'd1,
        EV_MATCH = 2'd2
    } pwm_event_e;

    function automatic logic all_ones(input logic [FRAC_W_DEF-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF,
    localparam int BW    = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_we,
    input  logic [TMR_W-1:0]  period_wd,
    input  logic              duty_hi_we,
    input  logic [TMR_W-1:0]  duty_hi_wd,
    input  logic              ctrl_we,
    input  logic [FRAC_W:0]   ctrl_wd,
    output logic [TMR_W-1:0]  period,
    output logic [BW-1:0]     duty_master,
    output logic              ctrl_en
);

    logic [TMR_W-1:0]  period_q;
    logic [TMR_W-1:0]  hi_q;
    logic [FRAC_W-1:0] lo_q;
    logic              en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            en_q     <= 1'b0;
        end else begin
            if (period_we)  period_q <= period_wd;
            if (duty_hi_we) hi_q     <= duty_hi_wd;
            if (ctrl_we) begin
                en_q <= ctrl_wd[FRAC_W];
                lo_q <= ctrl_wd[FRAC_W-1:0];
            end
        end
    end

    assign period      = period_q;
    assign duty_master = {hi_q, lo_q};
    assign ctrl_en     = en_q;

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF,
    localparam int BW    = TMR_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    output logic [BW-1:0]    base,
    output logic             wrap
);

    logic [BW-1:0] base_q;
    logic          phase_full;
    logic          count_hit;

    assign phase_full = &base_q[FRAC_W-1:0];
    assign count_hit  = (base_q[BW-1:FRAC_W] == period);
    assign wrap       = en && tick && phase_full && count_hit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            base_q <= '0;
        end else if (tick) begin
            base_q <= wrap ? '0 : base_q + 1'b1;
        end
    end

    assign base = base_q;

endmodule

// File: rtl/pwm10_outlatch.sv
module pwm10_outlatch #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF,
    localparam int BW    = TMR_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          wrap,
    input  logic [BW-1:0] base,
    input  logic [BW-1:0] duty_master,
    output logic [BW-1:0] slave,
    output logic          latch_q
);
    import pwm10_pkg::*;

    logic [BW-1:0] slave_q;
    logic          lat_q;
    logic [BW-1:0] base_next;
    pwm_event_e    ev;

    assign base_next = base + 1'b1;

    always_comb begin
        ev = EV_NONE;
        if (en && tick) begin
            if (wrap)                      ev = EV_WRAP;
            else if (base_next == slave_q) ev = EV_MATCH;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slave_q <= '0;
            lat_q   <= 1'b0;
        end else if (!en) begin
            lat_q   <= 1'b0;
        end else begin
            case (ev)
                EV_WRAP: begin
                    slave_q <= duty_master;
                    lat_q   <= (duty_master != '0);
                end
                EV_MATCH: lat_q <= 1'b0;
                default:  ;
            endcase
        end
    end

    assign slave   = slave_q;
    assign latch_q = lat_q;

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_we,
    input  logic [TMR_W-1:0]  period_wd,
    input  logic              duty_hi_we,
    input  logic [TMR_W-1:0]  duty_hi_wd,
    input  logic              ctrl_we,
    input  logic [FRAC_W:0]   ctrl_wd,
    input  logic              presc_en,
    input  logic              out_en,
    output logic              pin_o,
    output logic              pin_oe
);
    localparam int BW = TMR_W + FRAC_W;

    logic [TMR_W-1:0] period;
    logic [BW-1:0]    duty_master;
    logic             ctrl_en;
    logic [BW-1:0]    base;
    logic             wrap;
    logic [BW-1:0]    slave;
    logic             latch_q;

    pwm10_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst(rst),
        .period_we(period_we), .period_wd(period_wd),
        .duty_hi_we(duty_hi_we), .duty_hi_wd(duty_hi_wd),
        .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .period(period), .duty_master(duty_master), .ctrl_en(ctrl_en)
    );

    pwm10_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
        .clk(clk), .rst(rst), .en(ctrl_en), .tick(presc_en),
        .period(period), .base(base), .wrap(wrap)
    );

    pwm10_outlatch #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_out (
        .clk(clk), .rst(rst), .en(ctrl_en), .tick(presc_en),
        .wrap(wrap), .base(base), .duty_master(duty_master),
        .slave(slave), .latch_q(latch_q)
    );

    assign pin_oe = out_en;
    assign pin_o  = out_en & latch_q;

endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF,
    localparam int BW    = TMR_W + FRAC_W
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_en,
    input logic          ctrl_we,
    input logic          presc_en,
    input logic          out_en,
    input logic          pin_o,
    input logic          wrap,
    input logic          latch_q,
    input logic [BW-1:0] base,
    input logic [BW-1:0] slave
);

    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !pin_o);

    assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> !latch_q);

    assert_off_base_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (base == '0));

    assert_slave_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(slave));

    assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
        (slave == '0) |-> !latch_q);

    assert_rise_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> (base == '0));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !presc_en && !ctrl_we) |=> ($stable(latch_q) && $stable(base)));

endmodule

bind pwm10_gen pwm10_gen_chk #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_we(ctrl_we),
    .presc_en(presc_en), .out_en(out_en), .pin_o(pin_o), .wrap(wrap),
    .latch_q(latch_q), .base(base), .slave(slave)
);

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_we = 1'b0;
    logic [7:0] period_wd = '0;
    logic       duty_hi_we = 1'b0;
    logic [7:0] duty_hi_wd = '0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_wd = '0;
    logic       presc_en = 1'b0;
    logic       out_en = 1'b1;
    logic       pin_o;
    logic       pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pwm10_gen u_pwm10_gen (
        .clk(clk), .rst(rst),
        .period_we(period_we), .period_wd(period_wd),
        .duty_hi_we(duty_hi_we), .duty_hi_wd(duty_hi_wd),
        .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .presc_en(presc_en), .out_en(out_en),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // behavioural reference model
    int m_period, m_hi, m_lo, m_en, m_base, m_slave, m_lat;
    always @(posedge clk) begin
        int duty;
        bit wr;
        if (rst) begin
            m_period = 0; m_hi = 0; m_lo = 0; m_en = 0;
            m_base = 0; m_slave = 0; m_lat = 0;
        end else begin
            duty = m_hi * 4 + m_lo;
            wr = (m_en != 0) && presc_en && (m_base % 4 == 3) && (m_base / 4 == m_period);
            if (m_en == 0) begin
                m_lat = 0; m_base = 0;
            end else if (presc_en) begin
                if (wr) begin
                    m_slave = duty; m_lat = (duty != 0); m_base = 0;
                end else begin
                    if (m_base + 1 == m_slave) m_lat = 0;
                    m_base = (m_base + 1) % 1024;
                end
            end
            if (period_we)  m_period = period_wd;
            if (duty_hi_we) m_hi = duty_hi_wd;
            if (ctrl_we) begin m_en = ctrl_wd[2]; m_lo = ctrl_wd[1:0]; end
        end
    end

    always @(negedge clk) begin
        int exp_pin;
        if (!done) begin
            exp_pin = out_en ? m_lat : 0;
            checks++;
            if (pin_o !== exp_pin[0] || pin_oe !== out_en) begin
                failures++;
                $display("FAIL %s model: pin_o=%0b pin_oe=%0b expected %0d/%0b",
                         cur_req, pin_o, pin_oe, exp_pin, out_en);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_period(input int v);
        @(negedge clk); period_we = 1'b1; period_wd = v[7:0];
        @(negedge clk); period_we = 1'b0;
    endtask

    task automatic wr_hi(input int v);
        @(negedge clk); duty_hi_we = 1'b1; duty_hi_wd = v[7:0];
        @(negedge clk); duty_hi_we = 1'b0;
    endtask

    task automatic wr_ctrl(input int en, input int lo);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = {en[0], lo[1:0]};
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_o) cnt++;
        end
    endtask

    task automatic count_rise(input int n, output int cnt);
        logic prev;
        cnt = 0;
        prev = pin_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_o && !prev) cnt++;
            prev = pin_o;
        end
    endtask

    task automatic sync_rise();
        logic prev;
        prev = pin_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pin_o && !prev) return;
            prev = pin_o;
        end
    endtask

    initial begin
        int c;
        int stable_ok;
        // R1: reset state
        idle(3);
        check("R1 reset pin", pin_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset pin", pin_o, 0);

        presc_en = 1'b1;
        cur_req = "R3";
        wr_period(3);
        wr_hi(1);
        wr_ctrl(1, 1);          // duty 5, period 16 ticks
        idle(40);
        count_rise(64, c); check("R2 rises in 4 periods", c, 4);
        count_high(64, c); check("R3 high ticks duty 5", c, 20);

        cur_req = "R10";
        wr_ctrl(1, 2);          // duty {1,2} = 6
        idle(40);
        count_high(64, c); check("R10 low field duty 6", c, 24);

        cur_req = "R6";
        sync_rise();            // sample with time base 0
        duty_hi_we = 1'b1; duty_hi_wd = 8'd3;   // duty becomes 14
        @(negedge clk); duty_hi_we = 1'b0;
        idle(5);
        check("R6 old duty still used", pin_o, 0);
        idle(16);
        check("R6 new duty next period", pin_o, 1);

        cur_req = "R4";
        wr_hi(0); wr_ctrl(1, 0);
        idle(40);
        count_high(64, c); check("R4 zero duty low", c, 0);

        cur_req = "R5";
        wr_hi(4);               // duty 16 = full period
        idle(40);
        count_high(64, c); check("R5 duty equals period", c, 64);
        wr_hi(200);
        idle(40);
        count_high(64, c); check("R5 duty far above period", c, 64);

        cur_req = "R9";
        wr_hi(1); wr_ctrl(1, 2);
        idle(40);
        sync_rise();
        idle(2);
        presc_en = 1'b0;
        stable_ok = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pin_o !== 1'b1) stable_ok = 0;
        end
        check("R9 frozen while prescaler off", stable_ok, 1);
        presc_en = 1'b1;
        idle(20);

        cur_req = "R8";
        out_en = 1'b0;
        count_high(20, c); check("R8 pin low when not driven", c, 0);
        check("R8 pin_oe low", pin_oe, 0);
        out_en = 1'b1;
        @(negedge clk);
        check("R8 pin_oe high", pin_oe, 1);

        cur_req = "R7";
        wr_ctrl(0, 0);
        count_high(20, c); check("R7 off keeps pin low", c, 0);
        wr_ctrl(1, 2);
        count_high(15, c); check("R7 low until first boundary", c, 0);
        @(negedge clk);
        check("R7 rises at first boundary", pin_o, 1);

        cur_req = "R2";
        wr_period(6);           // 28 ticks
        wr_hi(2); wr_ctrl(1, 2); // duty 10
        idle(70);
        count_rise(56, c); check("R2 rises period 28", c, 2);
        count_high(56, c); check("R3 high ticks period 28", c, 20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule